// File: doc/BRIEF.md
# Bang-bang phase aligner

This block keeps a fast output clock in step with a system reference. Two slow square waves arrive at its inputs: a divided copy of the system clock, and a copy of the output clock that has been divided by four and then by an external gear ratio. The block watches the rising edge of each wave. In every comparison it notes which edge came first and moves a phase-select code by one tap. That code picks a tap of a delay line or a multiphase clock, and the loop drives the skew between the two edges toward zero. The code is a modulo index over `NTAPS` taps.

Both detector inputs are treated as slow data in the `clk` domain, and each passes through a synchronizer before its rising edge is detected. The loop is declared locked after a set number of back-to-back direction reversals, because that is how a bang-bang loop dithers once it has converged. A short run of steps in one direction clears the lock. While the output clock is stopped, a hold input freezes the loop so that the code is still there when the clock restarts. After a change of frequency multiplier, a relock pulse clears the lock state and keeps the code.

Top module: `pa_aligner`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge sets `phase_code_o` to 0 and `locked_o`, `step_up_o` and `step_dn_o` to 0. It also discards any half-finished comparison.
- R2: If the feedback input rises before the system input, one step up is taken. At the third rising clock edge after the system input's rising transition is applied, `step_up_o` pulses for one cycle and `phase_code_o` increases by one.
- R3: If the system input rises before the feedback input, one step down is taken. At the third rising clock edge after the feedback input's rising transition is applied, `step_dn_o` pulses for one cycle and `phase_code_o` decreases by one.
- R4: The code wraps modulo `NTAPS`. A step up from `NTAPS-1` gives 0, and a step down from 0 gives `NTAPS-1`.
- R5: If both inputs rise in the same clock cycle and no comparison is open, no step is taken and the code does not change.
- R6: Further rising edges of the input that opened a comparison do not start a new one. One step results when the other input rises.
- R7: `locked_o` becomes 1 together with the step that completes `LOCK_ALTS` consecutive direction reversals. Counting starts after reset or relock. With the default of 8, nine alternating steps are needed.
- R8: `locked_o` clears together with the step that completes `RUN_LIMIT` consecutive steps in one direction. The default is 4.
- R9: At any clock edge where `hold_i` is sampled high, no step is taken. The code and `locked_o` keep their values, and an open comparison is dropped.
- R10: A cycle with `relock_i` high clears `locked_o` and all direction history at the next edge. The code is not changed and no step is taken.
- R11: `step_up_o` and `step_dn_o` are never high together. `phase_code_o` changes only in a cycle where one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the whole block |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_div_i | input | 1 | Divided system clock (detector reference) |
| fb_div_i | input | 1 | Divided output-clock feedback |
| hold_i | input | 1 | Freeze the loop while the output clock is stopped |
| relock_i | input | 1 | Restart lock acquisition after a multiplier change |
| phase_code_o | output | CODE_W | Selected tap index, 0 to NTAPS-1 |
| locked_o | output | 1 | Loop is dithering about the aligned point |
| step_up_o | output | 1 | One-cycle pulse, code moved up |
| step_dn_o | output | 1 | One-cycle pulse, code moved down |

## Verification
A step, together with its code and lock change, appears at the third rising clock edge after the later of the two detector edges is driven. That is two synchronizer stages followed by the output register. Hold and relock act at the first edge that samples them. Inputs are driven just after a falling edge. At each following falling edge the bench advances its reference model by one clock and compares all outputs, so every expected value is taken exactly one edge after the inputs that cause it. The directed checks of code and lock are made at the end of each 20-cycle comparison window, well after the three-edge delay has passed.

// File: rtl/pa_pkg.sv
// Shared types for the bang-bang phase aligner.
package pa_pkg;
    // Which detector input opened the current comparison.
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_FB   = 2'd1,
        PEND_SYS  = 2'd2
    } pend_t;

    // One bang-bang decision.
    typedef struct packed {
        logic valid;
        logic up;
    } step_t;
endpackage

// File: rtl/pa_edge_sync.sv
// Synchronizes a slow input into clk and flags its rising edge.
// Assumes the input stays high or low for several clk cycles.
// The rise flag is high for the one cycle after the last sync stage goes high.
module pa_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh;

    // Shift chain: STAGES sync flops plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pa_bb_detect.sv
// Early/late detector. The first rising edge opens a comparison. The other
// input's edge closes it and yields one decision: up if feedback came first.
// Edges that coincide with nothing open give no decision. Flush drops state.
module pa_bb_detect
    import pa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fb_rise,
    input  logic  sys_rise,
    input  logic  flush,
    output step_t step
);
    pend_t pend, pend_n;

    // Next comparison state and decision.
    always_comb begin
        step   = '0;
        pend_n = pend;
        if (flush) begin
            pend_n = PEND_NONE;
        end else begin
            unique case (pend)
                PEND_NONE: begin
                    if (fb_rise && !sys_rise)      pend_n = PEND_FB;
                    else if (sys_rise && !fb_rise) pend_n = PEND_SYS;
                end
                PEND_FB: begin
                    if (sys_rise) begin
                        step   = '{valid: 1'b1, up: 1'b1};
                        pend_n = PEND_NONE;
                    end
                end
                PEND_SYS: begin
                    if (fb_rise) begin
                        step   = '{valid: 1'b1, up: 1'b0};
                        pend_n = PEND_NONE;
                    end
                end
                default: pend_n = PEND_NONE;
            endcase
        end
    end

    // Comparison state register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= PEND_NONE;
        else        pend <= pend_n;
    end
endmodule

// File: rtl/pa_lock_track.sv
// Lock tracker. Counts back-to-back direction reversals and same-direction
// runs. Sets lock at ALTS reversals and clears it at a run of RUN steps.
// Assumes step is a single-cycle decision; clear wipes history and lock.
module pa_lock_track
    import pa_pkg::*;
#(
    parameter int ALTS = 8,
    parameter int RUN  = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  step_t step,
    input  logic  clear,
    output logic  locked
);
    localparam int AW = $clog2(ALTS + 1);
    localparam int RW = $clog2(RUN + 1);
    localparam logic [AW-1:0] ALT_MAX = AW'(ALTS);
    localparam logic [RW-1:0] RUN_MAX = RW'(RUN);

    logic          have_last, last_up;
    logic [AW-1:0] alt_cnt, alt_n;
    logic [RW-1:0] run_cnt, run_n;
    logic          same_dir;

    // Saturating counters for the decision being taken.
    always_comb begin
        same_dir = have_last && (step.up == last_up);
        if (have_last && !same_dir)
            alt_n = (alt_cnt == ALT_MAX) ? alt_cnt : alt_cnt + 1'b1;
        else
            alt_n = '0;
        if (same_dir)
            run_n = (run_cnt == RUN_MAX) ? run_cnt : run_cnt + 1'b1;
        else
            run_n = RW'(1);
    end

    // History and lock registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            have_last <= 1'b0;
            last_up   <= 1'b0;
            alt_cnt   <= '0;
            run_cnt   <= '0;
            locked    <= 1'b0;
        end else if (step.valid) begin
            have_last <= 1'b1;
            last_up   <= step.up;
            alt_cnt   <= alt_n;
            run_cnt   <= run_n;
            if (run_n >= RUN_MAX)      locked <= 1'b0;
            else if (alt_n >= ALT_MAX) locked <= 1'b1;
        end
    end
endmodule

// File: rtl/pa_phase_acc.sv
// Phase code accumulator. Applies each decision as a one-tap move modulo
// NTAPS and registers the up/down debug pulses alongside the code.
module pa_phase_acc
    import pa_pkg::*;
#(
    parameter int NTAPS  = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_t             step,
    output logic [CODE_W-1:0] code,
    output logic              up,
    output logic              dn
);
    localparam logic [CODE_W-1:0] LAST = CODE_W'(NTAPS - 1);

    // Code update with wrap and the debug pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            up   <= 1'b0;
            dn   <= 1'b0;
        end else begin
            up <= step.valid & step.up;
            dn <= step.valid & ~step.up;
            if (step.valid) begin
                if (step.up) code <= (code == LAST) ? '0 : code + 1'b1;
                else         code <= (code == '0) ? LAST : code - 1'b1;
            end
        end
    end
endmodule

// File: rtl/pa_aligner.sv
// Bang-bang phase aligner top. Synchronizes both divided clocks, decides
// early/late per comparison, steps a modulo tap code and tracks lock.
// Assumes both inputs are much slower than clk. Hold and relock are synchronous.
module pa_aligner
    import pa_pkg::*;
#(
    parameter int NTAPS     = 16,
    parameter int SYNC      = 2,
    parameter int LOCK_ALTS = 8,
    parameter int RUN_LIMIT = 4,
    localparam int CODE_W   = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_div_i,
    input  logic              fb_div_i,
    input  logic              hold_i,
    input  logic              relock_i,
    output logic [CODE_W-1:0] phase_code_o,
    output logic              locked_o,
    output logic              step_up_o,
    output logic              step_dn_o
);
    logic  sys_rise, fb_rise;
    step_t raw_step, eff_step;

    pa_edge_sync #(.STAGES(SYNC)) u_sys_sync (
        .clk(clk), .rst_n(rst_n), .din(sys_div_i), .rise(sys_rise));

    pa_edge_sync #(.STAGES(SYNC)) u_fb_sync (
        .clk(clk), .rst_n(rst_n), .din(fb_div_i), .rise(fb_rise));

    pa_bb_detect u_det (
        .clk(clk), .rst_n(rst_n), .fb_rise(fb_rise), .sys_rise(sys_rise),
        .flush(hold_i | relock_i), .step(raw_step));

    // Gate decisions while the loop is frozen or restarting.
    always_comb begin
        eff_step       = raw_step;
        eff_step.valid = raw_step.valid & ~hold_i & ~relock_i;
    end

    pa_lock_track #(.ALTS(LOCK_ALTS), .RUN(RUN_LIMIT)) u_lock (
        .clk(clk), .rst_n(rst_n), .step(eff_step), .clear(relock_i),
        .locked(locked_o));

    pa_phase_acc #(.NTAPS(NTAPS), .CODE_W(CODE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .step(eff_step), .code(phase_code_o),
        .up(step_up_o), .dn(step_dn_o));
endmodule

// File: rtl/pa_aligner_chk.sv
// Property checker for pa_aligner, attached by bind.
module pa_aligner_chk #(
    parameter int NTAPS  = 16,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_i,
    input logic              relock_i,
    input logic [CODE_W-1:0] phase_code_o,
    input logic              locked_o,
    input logic              step_up_o,
    input logic              step_dn_o
);
    localparam logic [CODE_W-1:0] LAST = CODE_W'(NTAPS - 1);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (phase_code_o == '0 && !locked_o && !step_up_o && !step_dn_o));

    assert_up_moves_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && step_up_o) |->
        (phase_code_o == (($past(phase_code_o) == LAST) ? '0 : $past(phase_code_o) + 1'b1)));

    assert_dn_moves_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && step_dn_o) |->
        (phase_code_o == (($past(phase_code_o) == '0) ? LAST : $past(phase_code_o) - 1'b1)));

    assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hold_i)) |-> (!step_up_o && !step_dn_o));

    assert_relock_unlocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(relock_i)) |-> (!locked_o && !step_up_o && !step_dn_o));

    assert_steps_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up_o, step_dn_o}));

    assert_code_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !step_up_o && !step_dn_o) |-> $stable(phase_code_o));
endmodule

bind pa_aligner pa_aligner_chk #(.NTAPS(NTAPS), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .relock_i(relock_i),
    .phase_code_o(phase_code_o), .locked_o(locked_o),
    .step_up_o(step_up_o), .step_dn_o(step_dn_o));

// File: tb/sim_pa_aligner.sv
module sim_pa_aligner;
    localparam int NT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_div = 1'b0, fb_div = 1'b0, hold = 1'b0, relock = 1'b0;
    logic [3:0] code;
    logic       locked, up, dn;

    int total = 0, bad = 0, cycles = 0;
    int want = 0;

    // Reference model state (plain integers, updated once per clock).
    int q_sys[$], q_fb[$];
    int m_pend = 0, m_code = 0, m_lock = 0, m_have = 0, m_last = 0;
    int m_alt = 0, m_run = 0, m_up = 0, m_dn = 0;

    always #5 clk = ~clk;

    pa_aligner #(.NTAPS(NT)) u0 (
        .clk(clk), .rst_n(rst_n), .sys_div_i(sys_div), .fb_div_i(fb_div),
        .hold_i(hold), .relock_i(relock), .phase_code_o(code),
        .locked_o(locked), .step_up_o(up), .step_dn_o(dn));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock of the reference model, using the inputs sampled at that edge.
    task automatic model_clock();
        int sr, fr, decide, dir;
        sr = (q_sys[1] == 1 && q_sys[2] == 0);
        fr = (q_fb[1] == 1 && q_fb[2] == 0);
        q_sys.push_front(int'(sys_div)); void'(q_sys.pop_back());
        q_fb.push_front(int'(fb_div));   void'(q_fb.pop_back());
        if (!rst_n) begin
            q_sys = '{0, 0, 0}; q_fb = '{0, 0, 0};
            m_pend = 0; m_code = 0; m_lock = 0; m_have = 0; m_last = 0;
            m_alt = 0; m_run = 0; m_up = 0; m_dn = 0;
            return;
        end
        decide = 0; dir = 0;
        if (hold || relock) m_pend = 0;
        else if (m_pend == 0) m_pend = (fr && !sr) ? 1 : (sr && !fr) ? 2 : 0;
        else if (m_pend == 1 && sr) begin decide = 1; dir = 1; m_pend = 0; end
        else if (m_pend == 2 && fr) begin decide = 1; dir = 0; m_pend = 0; end
        m_up = decide && dir;
        m_dn = decide && !dir;
        if (relock) begin
            m_lock = 0; m_have = 0; m_alt = 0; m_run = 0;
        end else if (decide) begin
            if (m_have && dir != m_last) m_alt = (m_alt < 8) ? m_alt + 1 : 8; else m_alt = 0;
            if (m_have && dir == m_last) m_run = (m_run < 4) ? m_run + 1 : 4; else m_run = 1;
            m_have = 1; m_last = dir;
            if (m_run >= 4) m_lock = 0; else if (m_alt >= 8) m_lock = 1;
            m_code = dir ? (m_code + 1) % NT : (m_code + NT - 1) % NT;
        end
    endtask

    // Apply inputs for one cycle, then advance and compare the model (R11 cycle model).
    task automatic cyc(input logic s, input logic f);
        sys_div = s; fb_div = f;
        @(negedge clk);
        cycles++;
        model_clock();
        check(code == 4'(m_code), "R11 model code", int'(code), m_code);
        check(locked == m_lock[0] && up == m_up[0] && dn == m_dn[0],
              "R11 model flags", {locked, up, dn}, {m_lock[0], m_up[0], m_dn[0]});
    endtask

    // 20-cycle window: system rises at 5, feedback at 5+off.
    task automatic pair(input int off);
        for (int t = 0; t < 20; t++)
            cyc(t >= 5 && t < 15, t >= 5 + off && t < 15 + off);
    endtask

    task automatic lock_seq();
        for (int i = 0; i < 9; i++) begin
            pair((i % 2 == 0) ? -2 : 2);
            want = (i % 2 == 0) ? (want + 1) % NT : (want + NT - 1) % NT;
            if (i == 7) check(locked == 1'b0, "R7 not yet locked at 7 reversals", locked, 0);
        end
        check(locked == 1'b1, "R7 locked after 8 reversals", locked, 1);
        check(code == 4'(want), "R7 code after dither", code, want);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        q_sys = '{0, 0, 0}; q_fb = '{0, 0, 0};
        repeat (4) cyc(0, 0);
        check(code == 0 && locked == 0 && up == 0 && dn == 0, "R1 reset state", {code, locked, up, dn}, 0);
        rst_n = 1'b1;

        // R2 latency: system rises at t=7 (later edge); step shows 3 edges later.
        for (int t = 0; t < 20; t++) begin
            cyc(t >= 7 && t < 15, t >= 5 && t < 15);
            if (t == 8) check(up == 1'b0, "R2 step not early", up, 0);
            if (t == 9) check(up == 1'b1 && code == 1, "R2 step up on third edge", {up, code}, {1'b1, 4'd1});
            if (t == 10) check(up == 1'b0, "R2 single pulse", up, 0);
        end
        want = 1;
        pair(3);  want = 0;
        check(code == 4'(want), "R3 step down", code, want);
        pair(1);  want = NT - 1;
        check(code == 4'(want), "R4 wrap below zero", code, want);
        pair(-1); want = 0;
        check(code == 4'(want), "R4 wrap above top", code, want);
        pair(0);
        check(code == 4'(want), "R5 coincident edges no step", code, want);

        // R6: feedback rises twice before the system input rises once.
        for (int t = 0; t < 24; t++)
            cyc(t >= 15 && t < 20, (t >= 2 && t < 5) || (t >= 8 && t < 11));
        want = 1;
        check(code == 4'(want), "R6 one step for repeated opener", code, want);

        // R7: start from fresh history.
        relock = 1'b1; cyc(0, 0); relock = 1'b0;
        lock_seq();

        // R9: whole window under hold leaves code and lock alone.
        hold = 1'b1; pair(-2); hold = 1'b0;
        check(code == 4'(want), "R9 hold keeps code", code, want);
        check(locked == 1'b1, "R9 hold keeps lock", locked, 1);

        // R10: relock clears lock, keeps code.
        relock = 1'b1; cyc(0, 0); relock = 1'b0; cyc(0, 0);
        check(locked == 1'b0, "R10 relock clears lock", locked, 0);
        check(code == 4'(want), "R10 relock keeps code", code, want);

        // R8: relock, lock again (last step up), then same-direction run.
        lock_seq();
        pair(-2); pair(-2); want = (want + 2) % NT;
        check(locked == 1'b1, "R8 still locked at run of 3", locked, 1);
        pair(-2); want = (want + 1) % NT;
        check(locked == 1'b0, "R8 unlocked at run of 4", locked, 0);
        check(code == 4'(want), "R8 code after run", code, want);

        // R9: hold in mid-comparison drops the open feedback-first comparison.
        for (int t = 0; t < 20; t++) begin
            hold = (t >= 7 && t < 10);
            cyc(t >= 12 && t < 18, t >= 3 && t < 18);
        end
        hold = 1'b0;
        pair(2); want = (want + NT - 1) % NT;
        check(code == 4'(want), "R9 open comparison dropped", code, want);

        // R1 again: reset mid-run.
        rst_n = 1'b0; cyc(0, 0); cyc(0, 0);
        check(code == 0 && locked == 0, "R1 reset mid-run", {code, locked}, 0);
        rst_n = 1'b1;
        pair(-2);
        check(code == 1, "R2 after reset", code, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule